// File: doc/BRIEF.md
# I2C Master Command-Word Engine

The block is a single-master I2C controller steered entirely by 10-bit command words pushed into a transmit queue. Each word holds one byte plus two framing flags. One flag asks for a bus start ahead of the byte. The other marks the byte as the last of a transfer. The engine turns this word stream into START, repeated START, address, data and STOP activity on open-drain clock and data lines. It collects the slave's acknowledge after every byte it sends. For reads it clocks in a programmed number of bytes and stores them in a receive queue.

A typical use pushes a write-addressed word to set a register pointer. It then pushes a start-flagged read address, then one last-flagged word whose byte is the number of bytes to fetch. The host watches the queue-empty flags, a bus-busy flag and three interrupt lines. One interrupt means the engine is stalled for lack of words. One means a transfer has fully ended on the bus. One means the receive queue holds at least a chosen number of bytes.

Top module: `i2c_cmd_master`

## Requirements
- R1: A command word uses bit 8 as the start flag, bit 9 as the last-byte flag and bits 7:0 as the byte; a start-flagged word on a free bus produces START followed by the byte sent MSB first. A word without the start flag that arrives while the bus is free is discarded with no bus activity.
- R2: The address byte is the 7-bit slave address in bits 7:1 with the direction in bit 0 (1 = read). A start-flagged word that arrives while the engine owns the bus produces a repeated START.
- R3: After an acknowledged read address without the last-byte flag, the next word's byte N is a count. The engine receives N bytes into the receive queue in arrival order. It acknowledges each byte except the Nth, which it NAKs, and then drives STOP.
- R4: A word carrying the last-byte flag ends the transfer with STOP. It never raises the stalled interrupt. `irq_bus_idle` pulses for one cycle once STOP has completed.
- R5: When the engine owns the bus and needs a word while the transmit queue is empty, `irq_tx_empty` is high and SCL is held low until a word arrives.
- R6: A word with both flags set is a complete one-byte transfer: START, byte, STOP.
- R7: `tx_empty`, `rx_empty` and `bus_busy` report the queue and bus state. Out of reset, both queues are empty, the bus is not busy and both lines are released.
- R8: `irq_rx_level` is high while the receive queue holds at least `rx_thresh` bytes and `rx_thresh` is non-zero.
- R9: A NAK to a written byte makes the engine drive STOP and discard queued words up to and including the next last-flagged one. It also sets `nak_err`, which stays set until reset.
- R10: SDA drive changes only while SCL is low, apart from START and STOP. The drive of the two lines never changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Push `tx_word` into the transmit queue |
| tx_word | input | 10 | Command word: flags in bits 9:8, byte in 7:0 |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_thresh | input | RX_AW+1 | Receive occupancy threshold, 0 disables |
| bus_busy | output | 1 | Engine owns the bus (START issued, STOP not yet done) |
| nak_err | output | 1 | Sticky flag: a written byte was not acknowledged |
| irq_tx_empty | output | 1 | Engine stalled waiting for a command word |
| irq_bus_idle | output | 1 | One-cycle pulse when STOP completes |
| irq_rx_level | output | 1 | Receive occupancy reached the threshold |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line |

## Verification
A wrong sequencer state shows up on the bus within one bit time. It appears as a missing or extra START or STOP, or as a byte sent with the wrong bit pattern. The slave model at the pins turns each of these into a token that mismatches the scoreboard. A miscounted read shows within one byte: the wrong byte gets the NAK, or the receive queue ends up holding a different number of bytes. A broken flush or a non-sticky error flag shows only after the next STOP, as a leaked bus transfer or a cleared `nak_err`.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    localparam int WORD_W  = 10;
    localparam int F_START = 8;
    localparam int F_LAST  = 9;

    typedef enum logic [1:0] {
        BC_START,
        BC_RSTART,
        BC_STOP,
        BC_BIT
    } bit_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GO,
        S_TX,
        S_WAIT,
        S_RX,
        S_STOP,
        S_FLUSH
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_RISE,
        PH_HIGH,
        PH_TAIL
    } phy_state_e;
endpackage

// File: rtl/i2c_cmd_fifo.sv
module i2c_cmd_fifo #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [AW:0]   level
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, rd_ptr;
    logic         do_push, do_pop;

    assign level   = wr_ptr - rd_ptr;
    assign empty   = (level == '0);
    assign do_push = push && (level != (AW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bit_phy.sv
module i2c_bit_phy
    import i2c_cmd_pkg::*;
#(
    parameter int T_HI = 122,
    parameter int T_LO = 122
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  bit_cmd_e cmd,
    input  logic     tx_bit,
    output logic     done,
    output logic     rx_bit,
    output logic     scl_oe,
    output logic     sda_oe,
    input  logic     scl_in,
    input  logic     sda_in
);
    localparam int TMAX = (T_HI > T_LO) ? T_HI : T_LO;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] HI_LD = CW'(T_HI - 1);
    localparam logic [CW-1:0] LO_LD = CW'(T_LO - 1);

    phy_state_e st, nxt;
    bit_cmd_e   cmd_q;
    logic [CW-1:0] cnt;
    logic [1:0] scl_sync, sda_sync;
    logic       scl_s, sda_s, cnt_zero;

    assign scl_s    = scl_sync[1];
    assign sda_s    = sda_sync[1];
    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
        end else begin
            scl_sync <= {scl_sync[0], scl_in};
            sda_sync <= {sda_sync[0], sda_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PH_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            PH_IDLE: if (cmd_valid) nxt = (cmd == BC_START) ? PH_HOLD : PH_LOW;
            PH_HOLD: if (cnt_zero) nxt = PH_IDLE;
            PH_LOW:  if (cnt_zero) nxt = PH_RISE;
            PH_RISE: if (scl_s) nxt = PH_HIGH;
            PH_HIGH: if (cnt_zero) begin
                unique case (cmd_q)
                    BC_RSTART: nxt = PH_HOLD;
                    BC_STOP:   nxt = PH_TAIL;
                    default:   nxt = PH_IDLE;
                endcase
            end
            PH_TAIL: if (cnt_zero) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= BC_BIT;
            cnt    <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            done   <= 1'b0;
            rx_bit <= 1'b1;
        end else begin
            done <= 1'b0;
            unique case (st)
                PH_IDLE: if (cmd_valid) begin
                    cmd_q <= cmd;
                    if (cmd == BC_START) begin
                        sda_oe <= 1'b1;
                        cnt    <= HI_LD;
                    end else begin
                        scl_oe <= 1'b1;
                        sda_oe <= (cmd == BC_BIT) ? !tx_bit : (cmd == BC_STOP);
                        cnt    <= LO_LD;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        scl_oe <= 1'b1;
                        done   <= 1'b1;
                    end else cnt <= cnt - 1'b1;
                end
                PH_LOW: begin
                    if (cnt_zero) scl_oe <= 1'b0;
                    else          cnt <= cnt - 1'b1;
                end
                PH_RISE: if (scl_s) cnt <= HI_LD;
                PH_HIGH: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else begin
                        unique case (cmd_q)
                            BC_RSTART: begin
                                sda_oe <= 1'b1;
                                cnt    <= HI_LD;
                            end
                            BC_STOP: begin
                                sda_oe <= 1'b0;
                                cnt    <= HI_LD;
                            end
                            default: begin
                                rx_bit <= sda_s;
                                scl_oe <= 1'b1;
                                done   <= 1'b1;
                            end
                        endcase
                    end
                end
                PH_TAIL: begin
                    if (cnt_zero) done <= 1'b1;
                    else          cnt <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int T_HI  = 122,
    parameter int T_LO  = 122,
    parameter int TX_AW = 4,
    parameter int RX_AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_push,
    input  logic [9:0]       tx_word,
    output logic             tx_full,
    output logic             tx_empty,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic             rx_empty,
    input  logic [RX_AW:0]   rx_thresh,
    output logic             bus_busy,
    output logic             nak_err,
    output logic             irq_tx_empty,
    output logic             irq_bus_idle,
    output logic             irq_rx_level,
    output logic             scl_oe,
    input  logic             scl_in,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int TX_DEPTH = 1 << TX_AW;

    seq_state_e st, nxt;
    logic [WORD_W-1:0] word;
    logic [TX_AW:0]    tx_level;
    logic [RX_AW:0]    rx_level;
    logic              tx_pop, rx_push;
    logic [7:0]        rx_din;

    logic       phy_valid, phy_done, phy_rx, phy_txb;
    bit_cmd_e   phy_cmd;

    logic [7:0] shreg, rd_left;
    logic [3:0] bitn;
    logic       pend, owned, cur_stop, is_addr, rw_q, go_rs;
    logic       rd_wait, flush_req;

    i2c_cmd_fifo #(.W(WORD_W), .AW(TX_AW)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_word),
        .pop(tx_pop), .dout(word), .empty(tx_empty), .level(tx_level)
    );

    i2c_cmd_fifo #(.W(8), .AW(RX_AW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_data), .empty(rx_empty), .level(rx_level)
    );

    i2c_bit_phy #(.T_HI(T_HI), .T_LO(T_LO)) u_phy (
        .clk(clk), .rst_n(rst_n), .cmd_valid(phy_valid), .cmd(phy_cmd),
        .tx_bit(phy_txb), .done(phy_done), .rx_bit(phy_rx),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in)
    );

    assign tx_full      = (tx_level == (TX_AW+1)'(TX_DEPTH));
    assign bus_busy     = owned;
    assign irq_tx_empty = (st == S_WAIT) && tx_empty;
    assign irq_rx_level = (rx_thresh != '0) && (rx_level >= rx_thresh);
    assign tx_pop       = !tx_empty && (st == S_IDLE || st == S_WAIT || st == S_FLUSH);
    assign rx_push      = (st == S_RX) && phy_done && (bitn == 4'd7);
    assign rx_din       = {shreg[6:0], phy_rx};

    always_comb begin
        phy_valid = !pend && (st == S_GO || st == S_TX || st == S_RX || st == S_STOP);
        phy_cmd   = BC_BIT;
        phy_txb   = 1'b1;
        unique case (st)
            S_GO:   phy_cmd = go_rs ? BC_RSTART : BC_START;
            S_STOP: phy_cmd = BC_STOP;
            S_TX:   phy_txb = (bitn == 4'd8) ? 1'b1 : shreg[7];
            S_RX:   phy_txb = (bitn == 4'd8) ? (rd_left == 8'd1) : 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: if (!tx_empty && word[F_START]) nxt = S_GO;
            S_WAIT: if (!tx_empty) begin
                if (rd_wait)            nxt = (word[7:0] == 8'd0) ? S_STOP : S_RX;
                else if (word[F_START]) nxt = S_GO;
                else                    nxt = S_TX;
            end
            S_GO:   if (phy_done) nxt = S_TX;
            S_TX:   if (phy_done && bitn == 4'd8) nxt = (phy_rx || cur_stop) ? S_STOP : S_WAIT;
            S_RX:   if (phy_done && bitn == 4'd8 && rd_left == 8'd1) nxt = S_STOP;
            S_STOP: if (phy_done) nxt = flush_req ? S_FLUSH : S_IDLE;
            S_FLUSH: if (tx_empty || word[F_LAST]) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;  rd_left <= '0;  bitn <= '0;
            pend <= 1'b0; owned <= 1'b0; cur_stop <= 1'b0; is_addr <= 1'b0;
            rw_q <= 1'b0; go_rs <= 1'b0; rd_wait <= 1'b0; flush_req <= 1'b0;
            nak_err <= 1'b0; irq_bus_idle <= 1'b0;
        end else begin
            irq_bus_idle <= 1'b0;
            if (phy_done)       pend <= 1'b0;
            else if (phy_valid) pend <= 1'b1;
            unique case (st)
                S_IDLE, S_WAIT: if (!tx_empty) begin
                    if (st == S_WAIT && rd_wait) begin
                        rd_left <= word[7:0];
                        rd_wait <= 1'b0;
                        bitn    <= '0;
                    end else if (word[F_START] || st == S_WAIT) begin
                        shreg    <= word[7:0];
                        cur_stop <= word[F_LAST];
                        is_addr  <= word[F_START];
                        rw_q     <= word[0];
                        go_rs    <= owned;
                        bitn     <= '0;
                        if (word[F_START]) owned <= 1'b1;
                    end
                end
                S_TX: if (phy_done) begin
                    if (bitn != 4'd8) begin
                        shreg <= {shreg[6:0], 1'b0};
                        bitn  <= bitn + 1'b1;
                    end else begin
                        bitn <= '0;
                        if (phy_rx) begin
                            nak_err   <= 1'b1;
                            flush_req <= !cur_stop;
                        end else begin
                            rd_wait <= is_addr && rw_q && !cur_stop;
                        end
                    end
                end
                S_RX: if (phy_done) begin
                    if (bitn != 4'd8) begin
                        shreg <= {shreg[6:0], phy_rx};
                        bitn  <= bitn + 1'b1;
                    end else begin
                        bitn    <= '0;
                        rd_left <= rd_left - 1'b1;
                    end
                end
                S_STOP: if (phy_done) begin
                    owned        <= 1'b0;
                    irq_bus_idle <= 1'b1;
                    rd_wait      <= 1'b0;
                end
                S_FLUSH: if (tx_empty || word[F_LAST]) flush_req <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic bus_busy,
    input logic nak_err,
    input logic irq_tx_empty,
    input logic irq_bus_idle,
    input logic irq_rx_level,
    input logic rx_empty
);
    AST_LINES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $stable(scl_oe)); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> (!scl_oe && !sda_oe)); // R7
    AST_NAK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        nak_err |=> nak_err); // R9
    AST_IRQ_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_tx_empty && irq_bus_idle)); // R4
    AST_STALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |-> scl_oe); // R5
    AST_LEVEL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_level |-> !rx_empty); // R8
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .bus_busy(bus_busy), .nak_err(nak_err), .irq_tx_empty(irq_tx_empty),
    .irq_bus_idle(irq_bus_idle), .irq_rx_level(irq_rx_level), .rx_empty(rx_empty)
);

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
    localparam int RX_AW = 4;
    localparam logic [6:0] SLV = 7'h6C;
    localparam logic [3:0] K_ST = 1, K_RS = 2, K_SP = 3, K_WA = 4, K_WN = 5, K_MA = 6, K_MN = 7;

    logic clk = 0, rst_n = 0;
    logic tx_push = 0, rx_pop = 0;
    logic [9:0] tx_word = '0;
    logic [RX_AW:0] rx_thresh = 5'd4;
    logic tx_full, tx_empty, rx_empty, bus_busy, nak_err;
    logic irq_tx_empty, irq_bus_idle, irq_rx_level, scl_oe, sda_oe;
    logic [7:0] rx_data;
    logic s_drv = 0;
    wire scl_bus = !scl_oe;
    wire sda_bus = !(sda_oe | s_drv);

    i2c_cmd_master #(.T_HI(6), .T_LO(6), .TX_AW(4), .RX_AW(RX_AW)) dut (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_word(tx_word),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .rx_thresh(rx_thresh), .bus_busy(bus_busy),
        .nak_err(nak_err), .irq_tx_empty(irq_tx_empty), .irq_bus_idle(irq_bus_idle),
        .irq_rx_level(irq_rx_level), .scl_oe(scl_oe), .scl_in(scl_bus),
        .sda_oe(sda_oe), .sda_in(sda_bus)
    );

    always #5 clk = !clk;

    int n_total = 0, n_pass = 0;
    int idle_cnt = 0, stall_cnt = 0;
    logic stall_prev = 0;
    logic [11:0] exp_q[$];
    string       exp_r[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    endtask

    task automatic expect_tok(input logic [3:0] k, input logic [7:0] d, input string req);
        exp_q.push_back({k, d});
        exp_r.push_back(req);
    endtask

    task automatic emit(input logic [3:0] k, input logic [7:0] d);
        if (exp_q.size() == 0) chk(0, "R1", "unexpected bus token", int'({k, d}), 0);
        else begin
            logic [11:0] e;
            string r;
            e = exp_q.pop_front();
            r = exp_r.pop_front();
            chk(e == {k, d}, r, "bus token", int'({k, d}), int'(e));
        end
    endtask

    // slave model and monitor (samples away from the active edge)
    logic ps = 1, pd = 1, in_x = 0, rd = 0, aok = 0, arw = 0, mack = 0;
    int bc = 0, bidx = 0;
    logic [7:0] sh = '0, rv = '0;
    always @(negedge clk) begin
        if (irq_bus_idle) idle_cnt++;
        if (irq_tx_empty && !stall_prev) stall_cnt++;
        stall_prev = irq_tx_empty;
        if (rst_n) begin
            if (ps && scl_bus && pd && !sda_bus) begin
                emit(in_x ? K_RS : K_ST, 8'h00);
                in_x = 1; bc = 0; bidx = 0; rd = 0; s_drv = 0;
            end else if (ps && scl_bus && !pd && sda_bus) begin
                emit(K_SP, 8'h00);
                in_x = 0; rd = 0; s_drv = 0;
            end else if (in_x && !ps && scl_bus) begin
                if (bc < 8 && !rd) sh = {sh[6:0], sda_bus};
                if (bc == 8 && rd) begin
                    emit(sda_bus ? K_MN : K_MA, rv);
                    mack = !sda_bus;
                end
                bc++;
            end else if (in_x && ps && !scl_bus) begin
                if (bc == 8) begin
                    if (!rd) begin
                        if (bidx == 0) begin
                            aok = (sh[7:1] == SLV); arw = sh[0];
                            emit(aok ? K_WA : K_WN, sh);
                            s_drv = aok;
                        end else begin
                            emit(K_WA, sh);
                            s_drv = 1;
                        end
                    end else s_drv = 0;
                end else if (bc == 9) begin
                    bc = 0;
                    if (bidx == 0 && aok && arw) begin rd = 1; rv = 8'hA0; end
                    else if (rd && mack) rv = rv + 1;
                    else rd = 0;
                    bidx++;
                    s_drv = rd ? !rv[7] : 1'b0;
                end else if (rd && bc >= 1 && bc <= 7) s_drv = !rv[7 - bc];
            end
            ps = scl_bus;
            pd = !(sda_oe | s_drv);
        end
    end

    task automatic push_word(input logic [9:0] w);
        @(negedge clk); tx_push = 1; tx_word = w;
        @(negedge clk); tx_push = 0;
    endtask

    task automatic wait_idle(input int prev);
        while (idle_cnt <= prev) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic tokens_done(input string req);
        chk(exp_q.size() == 0, req, "missing bus tokens", exp_q.size(), 0);
        exp_q.delete(); exp_r.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        int p, s;
        repeat (3) @(negedge clk);
        // reset state R7 / R10
        chk(tx_empty == 1, "R7", "tx_empty at reset", tx_empty, 1);
        chk(rx_empty == 1, "R7", "rx_empty at reset", rx_empty, 1);
        chk(bus_busy == 0, "R7", "bus_busy at reset", bus_busy, 0);
        chk({scl_oe, sda_oe} == 2'b00, "R10", "lines at reset", {scl_oe, sda_oe}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1 / R4: write one byte
        expect_tok(K_ST, 0, "R1"); expect_tok(K_WA, 8'hD8, "R1");
        expect_tok(K_WA, 8'h12, "R1"); expect_tok(K_SP, 0, "R4");
        p = idle_cnt; s = stall_cnt;
        push_word(10'h1D8); push_word(10'h212);
        wait_idle(p);
        tokens_done("R1");
        chk(stall_cnt == s, "R4", "stall irq on last byte", stall_cnt - s, 0);
        chk(idle_cnt == p + 1, "R4", "bus idle pulses", idle_cnt - p, 1);
        chk(bus_busy == 0, "R7", "bus_busy after stop", bus_busy, 0);

        // R5: starved queue
        expect_tok(K_ST, 0, "R5"); expect_tok(K_WA, 8'hD8, "R5");
        expect_tok(K_WA, 8'hEF, "R5"); expect_tok(K_SP, 0, "R5");
        p = idle_cnt; s = stall_cnt;
        push_word(10'h1D8);
        while (!irq_tx_empty) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(scl_oe == 1, "R5", "SCL held low while stalled", scl_oe, 1);
        chk(bus_busy == 1, "R7", "bus_busy while stalled", bus_busy, 1);
        push_word(10'h2EF);
        wait_idle(p);
        tokens_done("R5");
        chk(stall_cnt == s + 1, "R5", "stall irq count", stall_cnt - s, 1);

        // R6: both flags in one word
        expect_tok(K_ST, 0, "R6"); expect_tok(K_WA, 8'hD8, "R6"); expect_tok(K_SP, 0, "R6");
        p = idle_cnt;
        push_word(10'h3D8);
        wait_idle(p);
        tokens_done("R6");

        // R2 / R3: register write then read of four bytes
        expect_tok(K_ST, 0, "R2"); expect_tok(K_WA, 8'hD8, "R2"); expect_tok(K_WA, 8'h05, "R2");
        expect_tok(K_RS, 0, "R2"); expect_tok(K_WA, 8'hD9, "R2");
        expect_tok(K_MA, 8'hA0, "R3"); expect_tok(K_MA, 8'hA1, "R3");
        expect_tok(K_MA, 8'hA2, "R3"); expect_tok(K_MN, 8'hA3, "R3");
        expect_tok(K_SP, 0, "R3");
        p = idle_cnt;
        push_word(10'h1D8); push_word(10'h005); push_word(10'h1D9); push_word(10'h204);
        wait_idle(p);
        tokens_done("R3");
        chk(irq_rx_level == 1, "R8", "rx level irq at threshold", irq_rx_level, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rx_data == 8'hA0 + 8'(i), "R3", "received byte", rx_data, 8'hA0 + i);
            if (i == 0) chk(irq_rx_level == 1, "R8", "level before pop", irq_rx_level, 1);
            rx_pop = 1; @(negedge clk); rx_pop = 0;
            if (i == 0) chk(irq_rx_level == 0, "R8", "level below threshold", irq_rx_level, 0);
        end
        chk(rx_empty == 1, "R7", "rx_empty after pops", rx_empty, 1);

        // R9: wrong address, remaining words flushed
        expect_tok(K_ST, 0, "R9"); expect_tok(K_WN, 8'h08, "R9"); expect_tok(K_SP, 0, "R9");
        p = idle_cnt;
        push_word(10'h108); push_word(10'h233);
        wait_idle(p);
        repeat (10) @(negedge clk);
        tokens_done("R9");
        chk(nak_err == 1, "R9", "nak_err set", nak_err, 1);
        chk(tx_empty == 1, "R9", "queue flushed", tx_empty, 1);

        // R1: start-less word on a free bus is dropped
        push_word(10'h055);
        repeat (60) @(negedge clk);
        chk(tx_empty == 1, "R1", "orphan word consumed", tx_empty, 1);
        chk(bus_busy == 0, "R1", "no bus ownership for orphan", bus_busy, 0);
        tokens_done("R1");

        // R9: flag stays set across a good transfer
        expect_tok(K_ST, 0, "R9"); expect_tok(K_WA, 8'hD8, "R9"); expect_tok(K_SP, 0, "R9");
        p = idle_cnt;
        push_word(10'h3D8);
        wait_idle(p);
        tokens_done("R9");
        chk(nak_err == 1, "R9", "nak_err sticky", nak_err, 1);

        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule